// File: doc/BRIEF.md
# Prioritised Level-Sensitive Interrupt Controller

This block collects up to 116 level-sensitive interrupt lines and presents a single registered IRQ line to one processor. Each source has an enable bit, a per-processor mask bit and a 4-bit priority. The source is eligible when its line is high, it is enabled, it is unmasked and its priority is strictly greater than the processor's task-priority threshold. Software changes enable and mask state by writing a source number, not a bit vector, to a set register or a clear register.

Source 0 is not driven by a line. It is the doorbell source, and it is pending when any bit of a 32-bit doorbell request vector is high and the matching bit of the doorbell mask register is also set. Reading the acknowledge register returns the winning source number and leaves all state unchanged. The winner is the lowest-numbered eligible source. When the prioritisation control bit is set, the winner is the highest priority instead, and a tie goes to the lowest number. The register port is a simple valid/ready bus that is always ready.

Top module: `prio_intc`

## Requirements
- R1: After reset every source is disabled and masked, every priority, the threshold, the prioritisation bit and the doorbell mask are zero, `irq_out` is low and an acknowledge read returns 0x3FF.
- R2: A write of source number n to address 0x004 enables source n. A write of n to 0x008 disables it.
- R3: A write of n to 0x804 unmasks source n. A write of n to 0x800 masks it.
- R4: The word at 0x100 + 4·n holds the priority of source n in bits [3:0]. Write data bits above [3:0] are ignored, and a read returns the priority zero-extended.
- R5: The threshold is held in bits [3:0] of 0x808 and can be read back. A source is delivered only when its priority is strictly greater than the threshold.
- R6: A read of 0x80C returns the winning source number in bits [9:0], or 0x3FF when no source is eligible. The read changes no state.
- R7: At 0x000, bit 0 is the read/write prioritisation control. Bits [12:2] read as the number of sources and are read-only, so reset reads 0x1D0.
- R8: With the prioritisation bit clear, the lowest-numbered eligible source wins. With it set, the highest priority wins, and ties go to the lowest number.
- R9: `irq_out` is the OR of all eligible sources, registered once. It follows a change in eligibility at the next clock edge.
- R10: A write of a value ≥ 116 to any of the four set/clear registers has no effect. This includes values whose low bits alias a valid number.
- R11: Source 0 is pending when (doorbell_req AND doorbell mask) is non-zero. The doorbell mask is read/write at 0x810.
- R12: `req_ready` is always high. The data for a read accepted at edge k is presented with `rsp_valid` high after edge k, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Always high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| line_in | input | 115 | Level interrupt lines for sources 115..1 |
| doorbell_req | input | 32 | Doorbell request bits feeding source 0 |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
A register write takes effect at the edge that accepts it. Eligibility and the acknowledge value therefore change right after that edge, and `irq_out` follows one edge later. Read data appears after the accepting edge. The bench drives on falling edges, and it issues reads only after a write task has returned past its accepting edge. Before every IRQ check it waits exactly one more falling edge, so that each result is sampled in the first half-cycle where it is due.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam logic [11:0] A_CTRL     = 12'h000;
  localparam logic [11:0] A_EN_SET   = 12'h004;
  localparam logic [11:0] A_EN_CLR   = 12'h008;
  localparam logic [11:0] A_CFG_BASE = 12'h100;
  localparam logic [11:0] A_MSK_SET  = 12'h800;
  localparam logic [11:0] A_MSK_CLR  = 12'h804;
  localparam logic [11:0] A_TASKPRI  = 12'h808;
  localparam logic [11:0] A_ACK      = 12'h80C;
  localparam logic [11:0] A_DBMSK    = 12'h810;

  // source number carried by a set/clear write is usable only below the count
  function automatic logic idx_ok(logic [31:0] v, int unsigned n);
    return v < n;
  endfunction

  // control word: bit 0 prioritisation, bits [12:2] source count
  function automatic logic [31:0] ctrl_word(logic pe, int unsigned n);
    logic [31:0] w;
    w = '0;
    w[12:2] = 11'(n);
    w[0] = pe;
    return w;
  endfunction
endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank #(
  parameter int unsigned NSRC = 116,
  parameter int unsigned PW   = 4,
  parameter int unsigned IW   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_set,
  input  logic               en_clr,
  input  logic               msk_set,
  input  logic               msk_clr,
  input  logic [IW-1:0]      op_idx,
  input  logic               cfg_we,
  input  logic [IW-1:0]      cfg_idx,
  input  logic [PW-1:0]      cfg_prio,
  input  logic [NSRC-1:0]    pend,
  input  logic [PW-1:0]      thr,
  output logic [NSRC-1:0]    elig,
  output logic [NSRC*PW-1:0] prio_flat
);
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] msk_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic          en_r;
    logic          msk_r;
    logic [PW-1:0] pr_r;
    logic          hit;
    assign hit = (op_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_r  <= 1'b0;
        msk_r <= 1'b1;
        pr_r  <= '0;
      end else begin
        if (en_set && hit)       en_r <= 1'b1;
        else if (en_clr && hit)  en_r <= 1'b0;
        if (msk_set && hit)      msk_r <= 1'b1;
        else if (msk_clr && hit) msk_r <= 1'b0;
        if (cfg_we && cfg_idx == IW'(g)) pr_r <= cfg_prio;
      end
    end
    assign en_q[g]  = en_r;
    assign msk_q[g] = msk_r;
    assign elig[g]  = pend[g] & en_r & ~msk_r & (pr_r > thr);
    assign prio_flat[g*PW +: PW] = pr_r;
  end

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_set |=> en_q[$past(op_idx)]);
  // R3
  msk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msk_clr |=> !msk_q[$past(op_idx)]);
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int unsigned NSRC = 116,
  parameter int unsigned PW   = 4,
  parameter int unsigned IW   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    elig,
  input  logic [NSRC*PW-1:0] prio_flat,
  input  logic               prio_en,
  output logic               any,
  output logic [IW-1:0]      win_idx
);
  logic [PW-1:0] best_p;

  // descending scan with >= leaves the lowest index on ties
  always_comb begin
    best_p  = '0;
    win_idx = '1;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && (!prio_en || prio_flat[i*PW +: PW] >= best_p)) begin
        best_p  = prio_flat[i*PW +: PW];
        win_idx = IW'(i);
      end
    end
  end
  assign any = |elig;

  // R8
  win_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> elig[win_idx]);
  // R6
  none_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any |-> (win_idx == '1));
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int unsigned NSRC = 116,
  parameter int unsigned PW   = 4,
  parameter int unsigned IW   = 10,
  parameter int unsigned DBW  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [11:0]      req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  input  logic [NSRC-1:1]  line_in,
  input  logic [DBW-1:0]   doorbell_req,
  output logic             irq_out
);
  import intc_pkg::*;

  localparam int unsigned CFG_END = 32'(A_CFG_BASE) + 4 * NSRC;

  logic               wr, rd, val_ok, cfg_hit;
  logic [IW-1:0]      op_idx, cfg_idx;
  logic               en_set, en_clr, msk_set, msk_clr;
  logic               prio_en_q;
  logic [PW-1:0]      thr_q;
  logic [DBW-1:0]     db_mask_q;
  logic [NSRC-1:0]    pend, elig;
  logic [NSRC*PW-1:0] prio_flat;
  logic               any;
  logic [IW-1:0]      win_idx;
  logic [31:0]        rd_mux;

  assign req_ready = 1'b1;
  assign wr      = req_valid & req_write;
  assign rd      = req_valid & ~req_write;
  assign val_ok  = idx_ok(req_wdata, NSRC);
  assign op_idx  = req_wdata[IW-1:0];
  assign en_set  = wr && req_addr == A_EN_SET  && val_ok;
  assign en_clr  = wr && req_addr == A_EN_CLR  && val_ok;
  assign msk_set = wr && req_addr == A_MSK_SET && val_ok;
  assign msk_clr = wr && req_addr == A_MSK_CLR && val_ok;
  assign cfg_hit = req_addr >= A_CFG_BASE && 32'(req_addr) < CFG_END &&
                   req_addr[1:0] == 2'b00;
  assign cfg_idx = IW'((req_addr - A_CFG_BASE) >> 2);
  assign pend    = {line_in, |(doorbell_req & db_mask_q)};

  intc_src_bank #(.NSRC(NSRC), .PW(PW), .IW(IW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .en_set(en_set), .en_clr(en_clr), .msk_set(msk_set), .msk_clr(msk_clr),
    .op_idx(op_idx),
    .cfg_we(wr && cfg_hit), .cfg_idx(cfg_idx), .cfg_prio(req_wdata[PW-1:0]),
    .pend(pend), .thr(thr_q), .elig(elig), .prio_flat(prio_flat)
  );

  intc_pick #(.NSRC(NSRC), .PW(PW), .IW(IW)) u_pick (
    .clk(clk), .rst_n(rst_n), .elig(elig), .prio_flat(prio_flat),
    .prio_en(prio_en_q), .any(any), .win_idx(win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_en_q <= 1'b0;
      thr_q     <= '0;
      db_mask_q <= '0;
    end else if (wr) begin
      if (req_addr == A_CTRL)    prio_en_q <= req_wdata[0];
      if (req_addr == A_TASKPRI) thr_q     <= req_wdata[PW-1:0];
      if (req_addr == A_DBMSK)   db_mask_q <= req_wdata[DBW-1:0];
    end
  end

  always_comb begin
    case (req_addr)
      A_CTRL:    rd_mux = ctrl_word(prio_en_q, NSRC);
      A_TASKPRI: rd_mux = 32'(thr_q);
      A_ACK:     rd_mux = 32'(win_idx);
      A_DBMSK:   rd_mux = 32'(db_mask_q);
      default:   rd_mux = cfg_hit ? 32'(prio_flat[cfg_idx*PW +: PW]) : 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_out   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      irq_out   <= any;
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |=> irq_out);
  // R9
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any |=> !irq_out);
  // R12
  rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  // R5
  thr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (prio_flat[win_idx*PW +: PW] > thr_q));
endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [11:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         req_ready, rsp_valid, irq_out;
  logic [31:0]  rsp_rdata;
  logic [115:1] line_in = '0;
  logic [31:0]  doorbell_req = '0;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  prio_intc uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .line_in(line_in),
    .doorbell_req(doorbell_req), .irq_out(irq_out)
  );

  function automatic logic [11:0] cfg_a(int n);
    return 12'(12'h100 + 4 * n);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 rsp_valid", 32'(rsp_valid), 32'd1);
    d = rsp_rdata;
  endtask

  task automatic irq_is(string req, logic exp);
    @(negedge clk);
    chk(req, 32'(irq_out), 32'(exp));
  endtask

  task automatic ack_is(string req, logic [31:0] exp);
    logic [31:0] d;
    rd(12'h80C, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq at reset", 32'(irq_out), 32'd0);
    chk("R12 ready", 32'(req_ready), 32'd1);
    rd(12'h000, d); chk("R7 ctrl reset", d, 32'h1D0);
    ack_is("R1 ack at reset", 32'h3FF);
  endtask

  task automatic t_basic;
    logic [31:0] d;
    line_in[5] = 1'b1;
    wr(cfg_a(5), 32'hFFFF_FFF3);
    rd(cfg_a(5), d); chk("R4 prio readback", d, 32'd3);
    wr(12'h004, 32'd5);
    irq_is("R3 masked at reset", 1'b0);
    wr(12'h804, 32'd5);
    irq_is("R9 irq raised", 1'b1);
    ack_is("R6 ack single", 32'd5);
  endtask

  task automatic t_thresh;
    logic [31:0] d;
    wr(12'h808, 32'd3);
    irq_is("R5 equal threshold blocks", 1'b0);
    ack_is("R5 ack blocked", 32'h3FF);
    rd(12'h808, d); chk("R5 thr readback", d, 32'd3);
    wr(12'h808, 32'd2);
    irq_is("R5 above threshold", 1'b1);
  endtask

  task automatic t_enmask;
    wr(12'h008, 32'd5);
    irq_is("R2 clear-enable", 1'b0);
    wr(12'h004, 32'd5);
    irq_is("R2 set-enable", 1'b1);
    wr(12'h800, 32'd5);
    irq_is("R3 set-mask", 1'b0);
    ack_is("R3 masked ack", 32'h3FF);
    wr(12'h804, 32'd5);
    irq_is("R3 clear-mask", 1'b1);
  endtask

  task automatic t_arbit;
    logic [31:0] d;
    line_in[9] = 1'b1; line_in[20] = 1'b1;
    wr(cfg_a(9), 32'd7);  wr(cfg_a(20), 32'd7);
    wr(12'h004, 32'd9);   wr(12'h004, 32'd20);
    wr(12'h804, 32'd9);   wr(12'h804, 32'd20);
    ack_is("R8 lowest index", 32'd5);
    wr(12'h000, 32'd1);
    rd(12'h000, d); chk("R7 ctrl prio bit", d, 32'h1D1);
    ack_is("R8 tie lowest index", 32'd9);
    wr(cfg_a(20), 32'd9);
    ack_is("R8 highest prio", 32'd20);
    wr(cfg_a(20), 32'd7);
  endtask

  task automatic t_ack_stable;
    ack_is("R6 first ack", 32'd9);
    ack_is("R6 ack leaves state", 32'd9);
    irq_is("R6 irq kept", 1'b1);
  endtask

  task automatic t_range;
    wr(12'h008, 32'd5); wr(12'h008, 32'd9); wr(12'h008, 32'd20);
    irq_is("R2 all disabled", 1'b0);
    line_in[7] = 1'b1;
    wr(cfg_a(7), 32'd6);
    wr(12'h804, 32'd7);
    wr(12'h004, 32'h407);
    irq_is("R10 aliased set-enable ignored", 1'b0);
    wr(12'h004, 32'd116);
    ack_is("R10 index 116 ignored", 32'h3FF);
    wr(12'h004, 32'd7);
    irq_is("R2 valid enable", 1'b1);
    wr(12'h800, 32'h407);
    irq_is("R10 aliased set-mask ignored", 1'b1);
    wr(12'h008, 32'h407);
    ack_is("R10 aliased clear-enable ignored", 32'd7);
    wr(12'h008, 32'd7);
    irq_is("R2 disable 7", 1'b0);
  endtask

  task automatic t_doorbell;
    logic [31:0] d;
    wr(cfg_a(0), 32'd4);
    wr(12'h004, 32'd0);
    wr(12'h804, 32'd0);
    doorbell_req = 32'h8;
    irq_is("R11 doorbell masked off", 1'b0);
    wr(12'h810, 32'h8);
    irq_is("R11 doorbell delivered", 1'b1);
    ack_is("R11 ack source 0", 32'd0);
    rd(12'h810, d); chk("R11 mask readback", d, 32'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_thresh;
    t_enmask;
    t_arbit;
    t_ack_stable;
    t_range;
    t_doorbell;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule